// File: doc/BRIEF.md
# Home-Node Coherence Directory

This block is the directory kept at the home node for a group of coherent lines. For every line it stores three things: a pointer to the node that last held the line exclusively, a full bit vector of the nodes that hold copies, and a flag that says whether the home's own memory copy is current. Requests arrive with a request kind, the node that sent them and a line index. The block works out the whole directory transition in the cycle the request arrives, with no multi-phase transaction. In the next cycle it sends the resulting messages. These are a direct reply from home memory, or a forward to the owner. An invalidation fan-out to the other copy holders may go with either. The invalidation count that the requester must wait for travels on the reply or forward.

Lines may be shared while dirty, so home memory is not updated on a read that is served by the owner. An optional configuration input changes this. When it is set, such a read is taken to write the data back, and home memory is marked current again. The owner always services what it is sent. Because of that, the block never refuses or retries a request, and it never waits for a completion message. A request may therefore arrive in every cycle, and each one sees the directory as the previous request left it.

Top module: `hdc_home_dir`

## Requirements
- R1: After reset, every line has owner HOME_ID, an empty sharer vector and a current home copy. All output channels are idle with every field at zero.
- R2: A request with req_type 0 (read), 1 (read-exclusive) or 2 (upgrade) produces exactly one of rsp_valid and fwd_valid one cycle later. The requester named there (rsp_dst, or fwd_req) equals req_src. req_type 3 produces no message and leaves the directory unchanged.
- R3: A read to a line whose home copy is current gets rsp_valid to the requester with rsp_data=1 and rsp_acks=0. The requester is added to the sharers, and the owner is unchanged.
- R4: A read to a line whose home copy is stale is forwarded to the owner (fwd_dst=owner) with fwd_excl=0 and fwd_acks=0. The requester is added to the sharers, the owner is unchanged, and no invalidation is sent.
- R5: With sharewb_en=1, a forwarded read marks the home copy current, so that later reads are answered from home. With sharewb_en=0 the home copy stays stale.
- R6: A read-exclusive, or an upgrade from a node that is not a sharer, sends inv_mask = sharers without the requester, and without the owner if the request is forwarded. inv_valid is high exactly when that mask is non-zero, and inv_req = req_src.
- R7: The count of ones in inv_mask appears on rsp_acks or on fwd_acks in the same cycle. When a channel is not valid, all of its fields are zero.
- R8: An upgrade from a node that is a current sharer is answered from home with rsp_data=0. Every other sharer, including a dirty owner, is invalidated.
- R9: A read-exclusive or upgrade to a line whose home copy is stale, from a non-sharer, is forwarded to the owner with fwd_excl=1. The owner is not in inv_mask.
- R10: After a read-exclusive or upgrade, the requester is the owner and the only sharer, and the home copy is stale. The request that follows, even in the next cycle, sees this state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sharewb_en | input | 1 | Forwarded reads refresh the home copy |
| req_valid | input | 1 | Request present this cycle |
| req_type | input | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 ignored |
| req_src | input | $clog2(NODES) | Requesting node |
| req_line | input | $clog2(LINES) | Line index |
| rsp_valid | output | 1 | Reply from home to requester |
| rsp_dst | output | $clog2(NODES) | Reply destination |
| rsp_data | output | 1 | Reply carries line data |
| rsp_acks | output | $clog2(NODES+1) | Invalidation acks to expect |
| fwd_valid | output | 1 | Request forwarded to owner |
| fwd_dst | output | $clog2(NODES) | Owner receiving the forward |
| fwd_req | output | $clog2(NODES) | Original requester |
| fwd_excl | output | 1 | Forward asks for exclusive data |
| fwd_acks | output | $clog2(NODES+1) | Ack count relayed to requester |
| inv_valid | output | 1 | Invalidations issued |
| inv_mask | output | NODES | Nodes to invalidate |
| inv_req | output | $clog2(NODES) | Node the acks go to |

## Verification
On every cycle the assertions check these things: each request of a legal kind yields exactly one reply or forward, and it names the right requester. Ignored kinds are silent. Reads never invalidate. The requester and a forwarded owner are never in the invalidation mask, and the ack count on the reply or forward matches the mask. What the directory actually holds can only be shown by the bench's scenarios, which compare each message against a reference directory kept per line. These scenarios cover owner tracking across dirty sharing, the sharing-writeback mode, upgrades from sharers and from non-sharers, and back-to-back requests to the same line.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
  typedef enum logic [1:0] {
    RQ_READ = 2'd0,
    RQ_RDEX = 2'd1,
    RQ_UPGR = 2'd2,
    RQ_NONE = 2'd3
  } req_kind_e;
endpackage

// File: rtl/hdc_dir_store.sv
module hdc_dir_store #(
  parameter int NODES   = 4,
  parameter int LINES   = 8,
  parameter int HOME_ID = 0,
  localparam int NW = $clog2(NODES),
  localparam int LW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LW-1:0]    rd_line,
  output logic [NW-1:0]    rd_owner,
  output logic [NODES-1:0] rd_sharers,
  output logic             rd_hvalid,
  input  logic             wr_en,
  input  logic [LW-1:0]    wr_line,
  input  logic [NW-1:0]    wr_owner,
  input  logic [NODES-1:0] wr_sharers,
  input  logic             wr_hvalid
);
  logic [NW-1:0]    owner_q   [LINES];
  logic [NODES-1:0] sharers_q [LINES];
  logic [LINES-1:0] hvalid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        owner_q[i]   <= NW'(HOME_ID);
        sharers_q[i] <= '0;
      end
      hvalid_q <= '1;
    end else if (wr_en) begin
      owner_q[wr_line]   <= wr_owner;
      sharers_q[wr_line] <= wr_sharers;
      hvalid_q[wr_line]  <= wr_hvalid;
    end
  end

  assign rd_owner   = owner_q[rd_line];
  assign rd_sharers = sharers_q[rd_line];
  assign rd_hvalid  = hvalid_q[rd_line];
endmodule

// File: rtl/hdc_decide.sv
module hdc_decide #(
  parameter int NODES = 4,
  localparam int NW = $clog2(NODES),
  localparam int CW = $clog2(NODES + 1)
) (
  input  logic [1:0]       kind,
  input  logic             valid,
  input  logic [NW-1:0]    src,
  input  logic [NW-1:0]    owner,
  input  logic [NODES-1:0] sharers,
  input  logic             hvalid,
  input  logic             sharewb,
  output logic             upd,
  output logic [NW-1:0]    n_owner,
  output logic [NODES-1:0] n_sharers,
  output logic             n_hvalid,
  output logic             rsp_v,
  output logic             rsp_d,
  output logic             fwd_v,
  output logic             fwd_x,
  output logic [NODES-1:0] inv,
  output logic [CW-1:0]    acks
);
  import hdc_pkg::*;

  function automatic logic [CW-1:0] popc(input logic [NODES-1:0] v);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < NODES; i++) c = c + CW'(v[i]);
    return c;
  endfunction

  logic [NODES-1:0] src_bit, own_bit;
  logic             src_shares;

  assign src_bit    = NODES'(1) << src;
  assign own_bit    = NODES'(1) << owner;
  assign src_shares = |(sharers & src_bit);

  always_comb begin
    upd       = 1'b0;
    n_owner   = owner;
    n_sharers = sharers;
    n_hvalid  = hvalid;
    rsp_v     = 1'b0;
    rsp_d     = 1'b0;
    fwd_v     = 1'b0;
    fwd_x     = 1'b0;
    inv       = '0;
    if (valid) begin
      case (kind)
        RQ_READ: begin
          upd       = 1'b1;
          n_sharers = sharers | src_bit;
          n_hvalid  = hvalid | sharewb;
          rsp_v     = hvalid;
          rsp_d     = hvalid;
          fwd_v     = !hvalid;
        end
        RQ_RDEX, RQ_UPGR: begin
          upd       = 1'b1;
          n_owner   = src;
          n_sharers = src_bit;
          n_hvalid  = 1'b0;
          if (kind == RQ_UPGR && src_shares) begin
            inv   = sharers & ~src_bit;
            rsp_v = 1'b1;
          end else if (hvalid) begin
            inv   = sharers & ~src_bit;
            rsp_v = 1'b1;
            rsp_d = 1'b1;
          end else begin
            inv   = sharers & ~src_bit & ~own_bit;
            fwd_v = 1'b1;
            fwd_x = 1'b1;
          end
        end
        default: upd = 1'b0;
      endcase
    end
  end

  assign acks = popc(inv);
endmodule

// File: rtl/hdc_home_dir.sv
module hdc_home_dir #(
  parameter int NODES   = 4,
  parameter int LINES   = 8,
  parameter int HOME_ID = 0,
  localparam int NW = $clog2(NODES),
  localparam int LW = $clog2(LINES),
  localparam int CW = $clog2(NODES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sharewb_en,
  input  logic             req_valid,
  input  logic [1:0]       req_type,
  input  logic [NW-1:0]    req_src,
  input  logic [LW-1:0]    req_line,
  output logic             rsp_valid,
  output logic [NW-1:0]    rsp_dst,
  output logic             rsp_data,
  output logic [CW-1:0]    rsp_acks,
  output logic             fwd_valid,
  output logic [NW-1:0]    fwd_dst,
  output logic [NW-1:0]    fwd_req,
  output logic             fwd_excl,
  output logic [CW-1:0]    fwd_acks,
  output logic             inv_valid,
  output logic [NODES-1:0] inv_mask,
  output logic [NW-1:0]    inv_req
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NW-1:0]    cur_owner, n_owner;
  logic [NODES-1:0] cur_sharers, n_sharers, inv_d;
  logic             cur_hvalid, n_hvalid, upd;
  logic             rsp_v_d, rsp_d_d, fwd_v_d, fwd_x_d;
  logic [CW-1:0]    acks_d;

  hdc_dir_store #(.NODES(NODES), .LINES(LINES), .HOME_ID(HOME_ID)) u_store (
    .clk(clk), .rst_n(rst_sync_n),
    .rd_line(req_line), .rd_owner(cur_owner), .rd_sharers(cur_sharers),
    .rd_hvalid(cur_hvalid),
    .wr_en(upd), .wr_line(req_line), .wr_owner(n_owner),
    .wr_sharers(n_sharers), .wr_hvalid(n_hvalid)
  );

  hdc_decide #(.NODES(NODES)) u_decide (
    .kind(req_type), .valid(req_valid), .src(req_src),
    .owner(cur_owner), .sharers(cur_sharers), .hvalid(cur_hvalid),
    .sharewb(sharewb_en),
    .upd(upd), .n_owner(n_owner), .n_sharers(n_sharers), .n_hvalid(n_hvalid),
    .rsp_v(rsp_v_d), .rsp_d(rsp_d_d), .fwd_v(fwd_v_d), .fwd_x(fwd_x_d),
    .inv(inv_d), .acks(acks_d)
  );

  // next-state of the message registers
  logic             rsp_valid_n, rsp_data_n, fwd_valid_n, fwd_excl_n, inv_valid_n;
  logic [NW-1:0]    rsp_dst_n, fwd_dst_n, fwd_req_n, inv_req_n;
  logic [CW-1:0]    rsp_acks_n, fwd_acks_n;
  logic [NODES-1:0] inv_mask_n;

  always_comb begin
    rsp_valid_n = rsp_v_d;
    rsp_dst_n   = rsp_v_d ? req_src : '0;
    rsp_data_n  = rsp_d_d;
    rsp_acks_n  = rsp_v_d ? acks_d : '0;
    fwd_valid_n = fwd_v_d;
    fwd_dst_n   = fwd_v_d ? cur_owner : '0;
    fwd_req_n   = fwd_v_d ? req_src : '0;
    fwd_excl_n  = fwd_x_d;
    fwd_acks_n  = fwd_v_d ? acks_d : '0;
    inv_valid_n = |inv_d;
    inv_mask_n  = inv_d;
    inv_req_n   = (|inv_d) ? req_src : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0; rsp_dst <= '0; rsp_data <= 1'b0; rsp_acks <= '0;
      fwd_valid <= 1'b0; fwd_dst <= '0; fwd_req <= '0; fwd_excl <= 1'b0;
      fwd_acks  <= '0;
      inv_valid <= 1'b0; inv_mask <= '0; inv_req <= '0;
    end else begin
      rsp_valid <= rsp_valid_n; rsp_dst <= rsp_dst_n;
      rsp_data  <= rsp_data_n;  rsp_acks <= rsp_acks_n;
      fwd_valid <= fwd_valid_n; fwd_dst <= fwd_dst_n;
      fwd_req   <= fwd_req_n;   fwd_excl <= fwd_excl_n;
      fwd_acks  <= fwd_acks_n;
      inv_valid <= inv_valid_n; inv_mask <= inv_mask_n;
      inv_req   <= inv_req_n;
    end
  end
endmodule

// File: rtl/hdc_home_dir_chk.sv
module hdc_home_dir_chk #(
  parameter int NODES = 4,
  localparam int NW = $clog2(NODES),
  localparam int CW = $clog2(NODES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_type,
  input logic [NW-1:0]    req_src,
  input logic             rsp_valid,
  input logic [NW-1:0]    rsp_dst,
  input logic [CW-1:0]    rsp_acks,
  input logic             fwd_valid,
  input logic [NW-1:0]    fwd_dst,
  input logic [NW-1:0]    fwd_req,
  input logic [CW-1:0]    fwd_acks,
  input logic             inv_valid,
  input logic [NODES-1:0] inv_mask,
  input logic [NW-1:0]    inv_req
);
  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type != 2'd3) |=> (rsp_valid ^ fwd_valid)); // R2
  AST_SILENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_type == 2'd3) |=> (!rsp_valid && !fwd_valid && !inv_valid)); // R2
  AST_ANSWER_NAMES_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type != 2'd3) |=> ((rsp_valid ? rsp_dst : fwd_req) == $past(req_src))); // R2
  AST_READ_NO_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type == 2'd0) |=> !inv_valid); // R4
  AST_REQ_NOT_INV: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (inv_mask[inv_req] == 1'b0 && inv_mask != '0)); // R6
  AST_ACKS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || fwd_valid) |-> ((rsp_acks | fwd_acks) == CW'($countones(inv_mask)))); // R7
  AST_OWNER_NOT_INV: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> !inv_mask[fwd_dst]); // R9
endmodule

bind hdc_home_dir hdc_home_dir_chk #(.NODES(NODES)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .req_valid(req_valid), .req_type(req_type), .req_src(req_src),
  .rsp_valid(rsp_valid), .rsp_dst(rsp_dst), .rsp_acks(rsp_acks),
  .fwd_valid(fwd_valid), .fwd_dst(fwd_dst), .fwd_req(fwd_req),
  .fwd_acks(fwd_acks), .inv_valid(inv_valid), .inv_mask(inv_mask),
  .inv_req(inv_req)
);

// File: tb/tb_hdc_home_dir.sv
module tb_hdc_home_dir;
  localparam int NODES = 4, LINES = 8, HOME = 0;
  localparam int NW = $clog2(NODES), LW = $clog2(LINES), CW = $clog2(NODES + 1);
  localparam int OW = 3 + 4 * NW + 2 * CW + 3 + NODES;

  logic clk = 1'b0, rst_n = 1'b0, sharewb_en = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_type = '0;
  logic [NW-1:0] req_src = '0;
  logic [LW-1:0] req_line = '0;
  logic rsp_valid, rsp_data, fwd_valid, fwd_excl, inv_valid;
  logic [NW-1:0] rsp_dst, fwd_dst, fwd_req, inv_req;
  logic [CW-1:0] rsp_acks, fwd_acks;
  logic [NODES-1:0] inv_mask;

  always #5 clk = ~clk;

  hdc_home_dir #(.NODES(NODES), .LINES(LINES), .HOME_ID(HOME)) dut (.*);

  int checks = 0, fails = 0;
  logic [NW-1:0]    m_own [LINES];
  logic [NODES-1:0] m_shr [LINES];
  logic             m_hv  [LINES];

  function automatic logic [OW-1:0] pack_out(
      logic rv, logic [NW-1:0] rd, logic rdt, logic [CW-1:0] ra,
      logic fv, logic [NW-1:0] fd, logic [NW-1:0] fr, logic fx, logic [CW-1:0] fa,
      logic iv, logic [NODES-1:0] im, logic [NW-1:0] ir);
    return {rv, rd, rdt, ra, fv, fd, fr, fx, fa, iv, im, ir};
  endfunction

  function automatic logic [CW-1:0] cnt(logic [NODES-1:0] v);
    logic [CW-1:0] c = '0;
    for (int i = 0; i < NODES; i++) c += CW'(v[i]);
    return c;
  endfunction

  task automatic check(string tag, logic [OW-1:0] act, logic [OW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < LINES; i++) begin
      m_own[i] = NW'(HOME); m_shr[i] = '0; m_hv[i] = 1'b1;
    end
  endtask

  // drive one request at a falling edge, check the messages one cycle later
  task automatic send(string tag, int kind, int src, int line);
    logic [NODES-1:0] sb, inv;
    logic [OW-1:0] exp;
    logic [NW-1:0] own;
    req_valid = 1'b1; req_type = 2'(kind); req_src = NW'(src); req_line = LW'(line);
    @(negedge clk);
    sb = NODES'(1) << src; own = m_own[line];
    exp = '0;
    if (kind == 0) begin
      if (m_hv[line]) exp = pack_out(1, NW'(src), 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      else            exp = pack_out(0, 0, 0, 0, 1, own, NW'(src), 0, 0, 0, 0, 0);
      m_shr[line] |= sb;
      if (sharewb_en) m_hv[line] = 1'b1;
    end else if (kind == 1 || kind == 2) begin
      if (kind == 2 && (m_shr[line] & sb) != 0) begin
        inv = m_shr[line] & ~sb;
        exp = pack_out(1, NW'(src), 0, cnt(inv), 0, 0, 0, 0, 0, |inv, inv, (|inv) ? NW'(src) : '0);
      end else if (m_hv[line]) begin
        inv = m_shr[line] & ~sb;
        exp = pack_out(1, NW'(src), 1, cnt(inv), 0, 0, 0, 0, 0, |inv, inv, (|inv) ? NW'(src) : '0);
      end else begin
        inv = m_shr[line] & ~sb & ~(NODES'(1) << own);
        exp = pack_out(0, 0, 0, 0, 1, own, NW'(src), 1, cnt(inv), |inv, inv, (|inv) ? NW'(src) : '0);
      end
      m_own[line] = NW'(src); m_shr[line] = sb; m_hv[line] = 1'b0;
    end
    check(tag, pack_out(rsp_valid, rsp_dst, rsp_data, rsp_acks, fwd_valid, fwd_dst,
                        fwd_req, fwd_excl, fwd_acks, inv_valid, inv_mask, inv_req), exp);
    req_valid = 1'b0; req_type = '0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 idle outputs", pack_out(rsp_valid, rsp_dst, rsp_data, rsp_acks, fwd_valid,
          fwd_dst, fwd_req, fwd_excl, fwd_acks, inv_valid, inv_mask, inv_req), '0);
    send("R1 fresh read from home", 0, 2, 5);
    send("R1 fresh rdex no acks", 1, 3, 6);
  endtask

  task automatic t_home_reads();
    send("R3 read home", 0, 1, 0);
    send("R3 second reader", 0, 2, 0);
    send("R6 rdex invalidates readers", 1, 3, 0);
  endtask

  task automatic t_dirty_forward();
    send("R9 take exclusive", 1, 1, 1);
    send("R4 read forwarded", 0, 2, 1);
    send("R4 read forwarded again", 0, 3, 1);
    send("R9 rdex forwarded, owner spared", 1, 0, 1);
    send("R10 back-to-back sees new owner", 0, 2, 1);
  endtask

  task automatic t_sharewb();
    sharewb_en = 1'b1;
    send("R5 exclusive", 1, 2, 2);
    send("R5 forwarded read with writeback", 0, 1, 2);
    send("R5 next read from home", 0, 3, 2);
    sharewb_en = 1'b0;
    send("R5 exclusive again", 1, 1, 3);
    send("R5 forwarded read no writeback", 0, 2, 3);
    send("R5 still forwarded", 0, 3, 3);
  endtask

  task automatic t_upgrade();
    send("R8 upgrade from dirty sharer", 2, 3, 3);
    send("R6 upgrade from non-sharer", 2, 0, 3);
    send("R10 repeated upgrade by owner", 2, 0, 3);
  endtask

  task automatic t_ignored();
    send("R2 kind 3 silent", 3, 1, 4);
    send("R2 after kind 3 line untouched", 0, 1, 4);
  endtask

  task automatic t_sweep();
    logic [15:0] lf = 16'hACE1;
    for (int n = 0; n < 150; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      sharewb_en = lf[9];
      send("R7 mixed sweep", int'(lf[1:0]), int'(lf[4:3]), int'(lf[7:5]));
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_home_reads();
    t_dirty_forward();
    t_sharewb();
    t_upgrade();
    t_ignored();
    t_sweep();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule